// File: doc/BRIEF.md
# Shift-Register LIFO Stack

This block is a synchronous last-in-first-out store for up to `DEPTH` words of `WIDTH` bits. It is a column of word cells that move together: a push moves every stored word one cell deeper and writes the incoming word into the top cell, and a pop moves every word one cell up. The head word therefore always sits in the top cell, and that cell drives the data output directly. Cells that hold no word are kept at zero, so an empty stack shows an all-zero output with no extra gating.

Each cell carries a valid bit that moves with its data. A three-state occupancy controller tracks whether the stack is empty (`ST_EMPTY`), partly filled (`ST_PARTIAL`) or full (`ST_FULL`). It chooses its next state from the request and two valid bits: the second cell, and the cell just above the bottom. This keeps the flag logic and the shift enables at a fixed depth for any `DEPTH` and `WIDTH`. The controller has these transitions:
- `ST_EMPTY` to `ST_PARTIAL` on a push, or to `ST_FULL` on a push when `DEPTH` is 1.
- `ST_PARTIAL` to `ST_FULL` on a push while the next-to-bottom cell is valid.
- `ST_PARTIAL` to `ST_EMPTY` on a pop while the second cell is invalid.
- `ST_FULL` to `ST_PARTIAL` on a pop, or to `ST_EMPTY` on a pop when `DEPTH` is 1.

The controller holds its state in every other case, including a refused push or pop. The user must never raise push and pop in the same cycle.

Top module: `lifo_shift_stack`

## Requirements
- R1: A push accepted at a clock edge makes `dout_o` equal the pushed word from the next cycle on.
- R2: A push moves every stored word one position deeper, so later pops return the words in reverse push order.
- R3: A push while `full_o` is high is ignored: `dout_o`, the flags and the stored words are unchanged.
- R4: A pop while the stack is not empty discards the head word, and the word below becomes `dout_o` in the next cycle.
- R5: A pop while `empty_o` is high is ignored: `empty_o` stays high and `dout_o` stays zero.
- R6: `full_o` is high exactly when `DEPTH` words are stored.
- R7: `empty_o` is high exactly when no word is stored.
- R8: `dout_o` is all zeros whenever the stack is empty, including after the stack was filled and drained.
- R9: A synchronous active-high `rst` empties the stack at any time: after it, `empty_o` is 1, `full_o` is 0 and `dout_o` is 0.
- R10: The outputs change only at clock edges. A change of `din_i` without a push has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| din_i | input | WIDTH | Word to push |
| dout_o | output | WIDTH | Head word; zero when the stack is empty |
| full_o | output | 1 | High when DEPTH words are stored |
| empty_o | output | 1 | High when no word is stored |

## Verification
The bench builds the stack with `DEPTH` = 4 and `WIDTH` = 8. A depth of four reaches the full state in a few pushes. It still leaves room for two `ST_PARTIAL` steps, so each controller transition is reached: entry from empty, the next-to-bottom step into full, and the last pop back to empty. An eight-bit word lets every pushed value be distinct and nonzero, so a lost, duplicated or reordered word, or a stale non-zero empty cell, shows up at `dout_o`.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    // Occupancy class of the stack
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/lifo_cell.sv
// One word cell of the shifting column, with its valid bit.
module lifo_cell #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_dn,
    input  logic             load_up,
    input  logic [WIDTH-1:0] above_dat,
    input  logic             above_vld,
    input  logic [WIDTH-1:0] below_dat,
    input  logic             below_vld,
    output logic [WIDTH-1:0] dat_q,
    output logic             vld_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_q <= '0;
            vld_q <= 1'b0;
        end else if (load_dn) begin
            dat_q <= above_dat;
            vld_q <= above_vld;
        end else if (load_up) begin
            dat_q <= below_dat;
            vld_q <= below_vld;
        end
    end

endmodule

// File: rtl/lifo_ctrl.sv
// Occupancy controller: decides whether a request is accepted and tracks the flags.
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  logic pop_i,
    input  logic near_full_i,   // next-to-bottom cell holds a word
    input  logic multi_i,       // second cell holds a word
    output logic shift_dn_o,
    output logic shift_up_o,
    output logic full_o,
    output logic empty_o
);

    localparam bit SINGLE = (DEPTH == 1);

    occ_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (push_i) state_d = SINGLE ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push_i && near_full_i)   state_d = ST_FULL;
                else if (pop_i && !multi_i)  state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop_i) state_d = SINGLE ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full_o     = 1'b0;
        empty_o    = 1'b0;
        shift_dn_o = 1'b0;
        shift_up_o = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                empty_o    = 1'b1;
                shift_dn_o = push_i;
            end
            ST_PARTIAL: begin
                shift_dn_o = push_i;
                shift_up_o = pop_i;
            end
            ST_FULL: begin
                full_o     = 1'b1;
                shift_up_o = pop_i;
            end
            default: empty_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/lifo_shift_stack.sv
// Shifting LIFO: the head word always lives in cell 0.
module lifo_shift_stack #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int LAST = DEPTH - 1;

    logic [WIDTH-1:0] cell_dat [DEPTH];
    logic [DEPTH-1:0] cell_vld;
    logic [WIDTH-1:0] above_dat [DEPTH];
    logic [DEPTH-1:0] above_vld;
    logic [WIDTH-1:0] below_dat [DEPTH];
    logic [DEPTH-1:0] below_vld;

    logic shift_dn, shift_up;
    logic near_full, multi;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        if (i == 0) begin : g_top
            assign above_dat[i] = din_i;
            assign above_vld[i] = 1'b1;
        end else begin : g_mid_up
            assign above_dat[i] = cell_dat[i-1];
            assign above_vld[i] = cell_vld[i-1];
        end

        if (i == LAST) begin : g_bottom
            assign below_dat[i] = '0;
            assign below_vld[i] = 1'b0;
        end else begin : g_mid_dn
            assign below_dat[i] = cell_dat[i+1];
            assign below_vld[i] = cell_vld[i+1];
        end

        lifo_cell #(.WIDTH(WIDTH)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .load_dn   (shift_dn),
            .load_up   (shift_up),
            .above_dat (above_dat[i]),
            .above_vld (above_vld[i]),
            .below_dat (below_dat[i]),
            .below_vld (below_vld[i]),
            .dat_q     (cell_dat[i]),
            .vld_q     (cell_vld[i])
        );
    end

    if (DEPTH > 1) begin : g_hints
        assign near_full = cell_vld[DEPTH-2];
        assign multi     = cell_vld[1];
    end else begin : g_hints_one
        assign near_full = 1'b0;
        assign multi     = 1'b0;
    end

    lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .near_full_i (near_full),
        .multi_i     (multi),
        .shift_dn_o  (shift_dn),
        .shift_up_o  (shift_up),
        .full_o      (full_o),
        .empty_o     (empty_o)
    );

    assign dout_o = cell_dat[0];

endmodule

// File: rtl/lifo_chk.sv
module lifo_chk #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             push_i,
    input logic             pop_i,
    input logic [WIDTH-1:0] din_i,
    input logic [WIDTH-1:0] dout_o,
    input logic             full_o,
    input logic             empty_o,
    input logic [DEPTH-1:0] cell_vld
);

    assert_push_head_R1: assert property (@(posedge clk) disable iff (rst)
        (push_i && !full_o) |=> (dout_o == $past(din_i)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o) |=> (full_o && $stable(dout_o)));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (pop_i && empty_o) |=> (empty_o && dout_o == '0));

    assert_full_flag_R6: assert property (@(posedge clk) disable iff (rst)
        full_o == cell_vld[DEPTH-1]);

    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (rst)
        empty_o == !cell_vld[0]);

    assert_zero_when_empty_R8: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> (dout_o == '0));

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (empty_o && !full_o && dout_o == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!push_i && !pop_i) |=> ($stable(dout_o) && $stable(full_o) && $stable(empty_o)));

    for (genvar i = 1; i < DEPTH; i++) begin : g_contig
        // R2: stored words stay packed against the top cell
        assert_vld_contiguous_R2: assert property (@(posedge clk) disable iff (rst)
            cell_vld[i] |-> cell_vld[i-1]);
    end

endmodule

bind lifo_shift_stack lifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .din_i    (din_i),
    .dout_o   (dout_o),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .cell_vld (cell_vld)
);

// File: tb/lifo_shift_stack_tb.sv
`timescale 1ns/1ps
module lifo_shift_stack_tb;

    localparam int DEPTH = 4;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] din_i = '0;
    logic [WIDTH-1:0] dout_o;
    logic             full_o;
    logic             empty_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model of the stack contents
    logic [WIDTH-1:0] mdl [DEPTH];
    int cnt = 0;

    always #2.5 clk = ~clk;

    lifo_shift_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .din_i   (din_i),
        .dout_o  (dout_o),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [WIDTH-1:0] e;
        e = (cnt == 0) ? '0 : mdl[0];
        check(dout_o == e, {req, " dout"}, 32'(dout_o), 32'(e));
        check(full_o == (cnt == DEPTH), {req, " full R6"}, 32'(full_o), 32'(cnt == DEPTH));
        check(empty_o == (cnt == 0), {req, " empty R7"}, 32'(empty_o), 32'(cnt == 0));
    endtask

    // one clock cycle with the given request; results checked a cycle later
    task automatic op(input bit ps, input bit pp, input logic [WIDTH-1:0] d);
        @(negedge clk);
        push_i = ps;
        pop_i  = pp;
        din_i  = d;
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        if (ps && cnt < DEPTH) begin
            for (int k = DEPTH - 1; k > 0; k--) mdl[k] = mdl[k-1];
            mdl[0] = d;
            cnt++;
        end else if (pp && cnt > 0) begin
            for (int k = 0; k < DEPTH - 1; k++) mdl[k] = mdl[k+1];
            mdl[DEPTH-1] = '0;
            cnt--;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check(empty_o == 1'b1, "R9 empty after reset", 32'(empty_o), 1);
        check(full_o == 1'b0, "R9 full after reset", 32'(full_o), 0);
        check(dout_o == '0, "R9 dout after reset", 32'(dout_o), 0);
    endtask

    task automatic t_fill_overflow();
        for (int i = 0; i < DEPTH; i++) begin
            op(1'b1, 1'b0, 8'hA0 + 8'(i));
            check(dout_o == 8'hA0 + 8'(i), "R1 head after push", 32'(dout_o), 32'(8'hA0 + 8'(i)));
            check_all("R1");
        end
        op(1'b1, 1'b0, 8'h5C);
        check(dout_o == 8'hA3, "R3 push on full ignored", 32'(dout_o), 32'hA3);
        check_all("R3");
        for (int i = DEPTH - 1; i >= 0; i--) begin
            check(dout_o == 8'hA0 + 8'(i), "R2 pop order", 32'(dout_o), 32'(8'hA0 + 8'(i)));
            op(1'b0, 1'b1, '0);
            check_all("R4");
        end
    endtask

    task automatic t_underflow();
        op(1'b0, 1'b1, '0);
        check(empty_o == 1'b1, "R5 pop on empty keeps empty", 32'(empty_o), 1);
        check(dout_o == '0, "R5 pop on empty dout", 32'(dout_o), 0);
        op(1'b0, 1'b1, '0);
        check_all("R5");
        op(1'b1, 1'b0, 8'h3E);
        check(dout_o == 8'h3E, "R5 push after underflow", 32'(dout_o), 32'h3E);
        op(1'b0, 1'b1, '0);
        check(dout_o == '0, "R8 zero after drain", 32'(dout_o), 0);
        check_all("R8");
    endtask

    task automatic t_interleave();
        op(1'b1, 1'b0, 8'h11);
        op(1'b1, 1'b0, 8'h22);
        op(1'b0, 1'b1, '0);
        check(dout_o == 8'h11, "R4 next word becomes head", 32'(dout_o), 32'h11);
        op(1'b1, 1'b0, 8'h33);
        op(1'b1, 1'b0, 8'h44);
        op(1'b1, 1'b0, 8'h55);
        check(full_o == 1'b1, "R6 full at DEPTH words", 32'(full_o), 1);
        check_all("R6");
        op(1'b0, 1'b1, '0);
        check(full_o == 1'b0, "R6 full drops after pop", 32'(full_o), 0);
        check_all("R2");
        for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, '0);
        check(empty_o == 1'b1, "R7 empty after drain", 32'(empty_o), 1);
        check_all("R7");
        // refill once to see that vacated cells were cleared
        op(1'b1, 1'b0, 8'h77);
        op(1'b0, 1'b1, '0);
        check(dout_o == '0, "R8 vacated cells zero", 32'(dout_o), 0);
    endtask

    task automatic t_idle_din();
        logic [WIDTH-1:0] held;
        op(1'b1, 1'b0, 8'h9A);
        held = dout_o;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            din_i = 8'hF0 + 8'(i);
            #1;
            check(dout_o == held, "R10 din alone no effect", 32'(dout_o), 32'(held));
        end
        @(negedge clk);
        check_all("R10");
    endtask

    task automatic t_reset_midway();
        op(1'b1, 1'b0, 8'hC1);
        op(1'b1, 1'b0, 8'hC2);
        do_reset();
        check(empty_o == 1'b1 && dout_o == '0, "R9 reset with data", 32'(dout_o), 0);
        check_all("R9");
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
        t_reset();
        t_fill_overflow();
        t_underflow();
        t_interleave();
        t_idle_din();
        t_reset_midway();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule